// File: doc/BRIEF.md
# Two-Tier Interrupt Cascade Bus Logic

This block lets one interrupt controller take part in a two-tier interrupt structure: one master and up to eight slaves, reaching up to 64 request levels over a private three-line cascade bus with no extra glue. It holds no priority logic of its own. The controller's acknowledge logic tells it which level is being acknowledged and when the vector phase runs, and this block decides who owns the data bus in that phase.

As master, it puts the number of the acknowledged level onto the cascade lines whenever a slave hangs off that level. When no slave hangs there, the master places the vector itself. As slave, it compares the cascade lines with its own programmed identity and enables its vector only on a match. The shared role/enable pin is an input that chooses the role in non-buffered operation. In buffered operation it is an output that enables the external data bus transceivers, and a programmed code picks the role. Every output is registered and follows its inputs by exactly one clock.

Top module: `cascade_bus`

## Requirements
- R1: When `bufcfg[1]` is 0 (non-buffered), `is_master` one cycle later equals `spen_in` (1 = master, 0 = slave), and `spen_oe` is 0.
- R2: When `bufcfg[1]` is 1 (buffered), `spen_in` is ignored. `bufcfg` = 2'b11 makes `is_master` 1 one cycle later, 2'b10 makes it 0, and `spen_oe` is 1.
- R3: When the role is master, `ack_active` is 1 and bit `ack_level` of `slave_map` is 1, then one cycle later `cas_oe` is 1 and `cas_out` equals `ack_level`.
- R4: When `cas_oe` is 0, `cas_out` is all zeros. A master whose acknowledged level has no slave, or that sees no acknowledge, does not drive the cascade lines.
- R5: A slave never drives the cascade lines (`cas_oe` is 0 whenever `is_master` is 0).
- R6: As master, `vec_en` is 1 one cycle after `vec_phase` is 1 only when bit `ack_level` of `slave_map` is 0.
- R7: As slave, `vec_en` is 1 one cycle after `vec_phase` is 1 only when `cas_in` equals `my_id`. Any other `cas_in` value leaves `vec_en` at 0.
- R8: `bus_drive` is 1 one cycle after either a vector enable condition (R6/R7) or `rd_status` is 1, and is 0 otherwise.
- R9: `spen_out` equals `bus_drive` in buffered mode (active-high transceiver enable) and is 0 in non-buffered mode.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bufcfg | input | 2 | Buffer/role code: 0x non-buffered, 10 buffered slave, 11 buffered master |
| spen_in | input | 1 | Role/enable pin sensed as input |
| spen_out | output | 1 | Role/enable pin driven value (transceiver enable) |
| spen_oe | output | 1 | Role/enable pin output enable |
| slave_map | input | LEVELS (8) | Master: bit i set when a slave is wired to request input i |
| my_id | input | CAS_W (3) | Slave: own identity, equal to the master input it is wired to |
| ack_active | input | 1 | Acknowledge sequence in progress |
| ack_level | input | CAS_W (3) | Level being acknowledged |
| vec_phase | input | 1 | Vector transfer phase of the acknowledge |
| rd_status | input | 1 | Status read is driving the data bus |
| cas_in | input | CAS_W (3) | Cascade lines sensed |
| cas_out | output | CAS_W (3) | Cascade lines driven value |
| cas_oe | output | 1 | Cascade lines output enable |
| is_master | output | 1 | Current role, 1 = master |
| vec_en | output | 1 | This controller places the vector on the data bus |
| bus_drive | output | 1 | This controller drives the data bus |

## Verification
A wrongly chosen role shows up one clock after the role inputs change, on `is_master`, `spen_oe` and on which vector enable fires. A bad slave-map lookup or a bad identity compare shows up as two controllers enabling a vector in the same vector phase, or as none at all, also one clock later. The registered cascade drive is checked in the same cycle as `cas_oe`, so a stale level or a floating bus on the cascade lines is seen at the next edge.

// File: rtl/cascade_pkg.sv
package cascade_pkg;

  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } role_e;

  // bit 1: buffered operation, bit 0: programmed role when buffered
  typedef enum logic [1:0] {
    CFG_PIN_A  = 2'b00,
    CFG_PIN_B  = 2'b01,
    CFG_BUF_SL = 2'b10,
    CFG_BUF_MS = 2'b11
  } bufcfg_e;

  function automatic logic is_buffered(input logic [1:0] cfg);
    return cfg[1];
  endfunction

  function automatic role_e pick_role(input logic [1:0] cfg, input logic pin);
    logic sel;
    sel = is_buffered(cfg) ? cfg[0] : pin;
    return sel ? ROLE_MASTER : ROLE_SLAVE;
  endfunction

endpackage

// File: rtl/cas_role_sel.sv
module cas_role_sel
  import cascade_pkg::*;
(
  input  logic [1:0] bufcfg,
  input  logic       spen_in,
  output role_e      role_now,
  output logic       pin_is_out
);

  always_comb begin
    role_now   = pick_role(bufcfg, spen_in);
    pin_is_out = is_buffered(bufcfg);
  end

endmodule

// File: rtl/cas_master_drv.sv
module cas_master_drv
  import cascade_pkg::*;
#(
  parameter int CAS_W  = 3,
  localparam int LEVELS = 1 << CAS_W
) (
  input  role_e              role_now,
  input  logic               ack_active,
  input  logic [CAS_W-1:0]   ack_level,
  input  logic [LEVELS-1:0]  slave_map,
  input  logic               vec_phase,
  output logic               slave_hit,
  output logic               drive_nx,
  output logic [CAS_W-1:0]   code_nx,
  output logic               mvec_nx
);

  function automatic logic level_has_slave(input logic [LEVELS-1:0] map,
                                           input logic [CAS_W-1:0] lvl);
    return map[lvl];
  endfunction

  logic am_master;

  always_comb begin
    am_master = (role_now == ROLE_MASTER);
    slave_hit = level_has_slave(slave_map, ack_level);
    drive_nx  = am_master && ack_active && slave_hit;
    code_nx   = drive_nx ? ack_level : '0;
    mvec_nx   = am_master && vec_phase && !slave_hit;
  end

endmodule

// File: rtl/cas_slave_cmp.sv
module cas_slave_cmp
  import cascade_pkg::*;
#(
  parameter int CAS_W = 3
) (
  input  role_e            role_now,
  input  logic             vec_phase,
  input  logic [CAS_W-1:0] cas_in,
  input  logic [CAS_W-1:0] my_id,
  output logic             id_match,
  output logic             svec_nx
);

  function automatic logic same_id(input logic [CAS_W-1:0] a,
                                   input logic [CAS_W-1:0] b);
    return (a ^ b) == '0;
  endfunction

  always_comb begin
    id_match = same_id(cas_in, my_id);
    svec_nx  = (role_now == ROLE_SLAVE) && vec_phase && id_match;
  end

endmodule

// File: rtl/cascade_bus.sv
module cascade_bus
  import cascade_pkg::*;
#(
  parameter int CAS_W  = 3,
  localparam int LEVELS = 1 << CAS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bufcfg,
  input  logic              spen_in,
  output logic              spen_out,
  output logic              spen_oe,
  input  logic [LEVELS-1:0] slave_map,
  input  logic [CAS_W-1:0]  my_id,
  input  logic              ack_active,
  input  logic [CAS_W-1:0]  ack_level,
  input  logic              vec_phase,
  input  logic              rd_status,
  input  logic [CAS_W-1:0]  cas_in,
  output logic [CAS_W-1:0]  cas_out,
  output logic              cas_oe,
  output logic              is_master,
  output logic              vec_en,
  output logic              bus_drive
);

  // named internal events, observed by the checker
  role_e            role_now;
  logic             pin_is_out;
  logic             slave_hit;
  logic             drive_nx;
  logic [CAS_W-1:0] code_nx;
  logic             mvec_nx;
  logic             id_match;
  logic             svec_nx;
  logic             vec_nx;
  logic             bus_nx;

  cas_role_sel u_role (
    .bufcfg     (bufcfg),
    .spen_in    (spen_in),
    .role_now   (role_now),
    .pin_is_out (pin_is_out)
  );

  cas_master_drv #(.CAS_W(CAS_W)) u_mst (
    .role_now   (role_now),
    .ack_active (ack_active),
    .ack_level  (ack_level),
    .slave_map  (slave_map),
    .vec_phase  (vec_phase),
    .slave_hit  (slave_hit),
    .drive_nx   (drive_nx),
    .code_nx    (code_nx),
    .mvec_nx    (mvec_nx)
  );

  cas_slave_cmp #(.CAS_W(CAS_W)) u_slv (
    .role_now  (role_now),
    .vec_phase (vec_phase),
    .cas_in    (cas_in),
    .my_id     (my_id),
    .id_match  (id_match),
    .svec_nx   (svec_nx)
  );

  always_comb begin
    vec_nx = mvec_nx || svec_nx;
    bus_nx = vec_nx || rd_status;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_master <= 1'b0;
      cas_oe    <= 1'b0;
      cas_out   <= '0;
      vec_en    <= 1'b0;
      bus_drive <= 1'b0;
      spen_oe   <= 1'b0;
      spen_out  <= 1'b0;
    end else begin
      is_master <= (role_now == ROLE_MASTER);
      cas_oe    <= drive_nx;
      cas_out   <= code_nx;
      vec_en    <= vec_nx;
      bus_drive <= bus_nx;
      spen_oe   <= pin_is_out;
      spen_out  <= pin_is_out && bus_nx;
    end
  end

endmodule

// File: rtl/cascade_bus_chk.sv
module cascade_bus_chk #(
  parameter int CAS_W  = 3,
  localparam int LEVELS = 1 << CAS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bufcfg,
  input logic              spen_in,
  input logic              spen_out,
  input logic              spen_oe,
  input logic [CAS_W-1:0]  my_id,
  input logic              ack_active,
  input logic [CAS_W-1:0]  ack_level,
  input logic [CAS_W-1:0]  cas_in,
  input logic [CAS_W-1:0]  cas_out,
  input logic              cas_oe,
  input logic              is_master,
  input logic              vec_en,
  input logic              bus_drive,
  input logic              slave_hit
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r1_pin_role: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(bufcfg[1])) |-> (is_master == $past(spen_in)) && !spen_oe);

  a_r2_prog_role: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(bufcfg[1])) |-> (is_master == $past(bufcfg[0])) && spen_oe);

  a_r3_cas_level: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cas_oe) |-> is_master && (cas_out == $past(ack_level)) && $past(ack_active));

  a_r3_cas_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && is_master && $past(ack_active) && $past(slave_hit)) |-> cas_oe);

  a_r4_cas_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_oe |-> (cas_out == '0));

  a_r5_slave_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> !cas_oe);

  a_r6_master_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && is_master && vec_en) |-> !$past(slave_hit));

  a_r7_slave_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !is_master && vec_en) |-> ($past(cas_in) == $past(my_id)));

  a_r8_vec_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    vec_en |-> bus_drive);

  a_r9_enable_pin: assert property (@(posedge clk) disable iff (!rst_n)
    spen_out |-> (spen_oe && bus_drive));

endmodule

bind cascade_bus cascade_bus_chk #(.CAS_W(CAS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bufcfg     (bufcfg),
  .spen_in    (spen_in),
  .spen_out   (spen_out),
  .spen_oe    (spen_oe),
  .my_id      (my_id),
  .ack_active (ack_active),
  .ack_level  (ack_level),
  .cas_in     (cas_in),
  .cas_out    (cas_out),
  .cas_oe     (cas_oe),
  .is_master  (is_master),
  .vec_en     (vec_en),
  .bus_drive  (bus_drive),
  .slave_hit  (slave_hit)
);

// File: tb/cascade_bus_test.sv
module cascade_bus_test;

  localparam int CW = 3;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    bufcfg = '0;
  logic          spen_in = 1'b0;
  logic          spen_out, spen_oe;
  logic [NL-1:0] slave_map = '0;
  logic [CW-1:0] my_id = '0;
  logic          ack_active = 1'b0;
  logic [CW-1:0] ack_level = '0;
  logic          vec_phase = 1'b0;
  logic          rd_status = 1'b0;
  logic [CW-1:0] cas_in = '0;
  logic [CW-1:0] cas_out;
  logic          cas_oe, is_master, vec_en, bus_drive;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cascade_bus #(.CAS_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .bufcfg(bufcfg), .spen_in(spen_in),
    .spen_out(spen_out), .spen_oe(spen_oe), .slave_map(slave_map),
    .my_id(my_id), .ack_active(ack_active), .ack_level(ack_level),
    .vec_phase(vec_phase), .rd_status(rd_status), .cas_in(cas_in),
    .cas_out(cas_out), .cas_oe(cas_oe), .is_master(is_master),
    .vec_en(vec_en), .bus_drive(bus_drive)
  );

  // expected values, recomputed from the requirements
  logic          x_mst, x_oe, x_vec, x_bus, x_poe, x_pout;
  logic [CW-1:0] x_cas;

  function automatic logic exp_master(input logic [1:0] cfg, input logic pin);
    if (cfg == 2'b11) return 1'b1;
    if (cfg == 2'b10) return 1'b0;
    return pin;
  endfunction

  function automatic logic has_slave(input logic [NL-1:0] m, input int lvl);
    return ((m >> lvl) & 1) != 0;
  endfunction

  task automatic predict();
    logic hs;
    x_mst = exp_master(bufcfg, spen_in);
    hs    = has_slave(slave_map, int'(ack_level));
    x_oe  = x_mst & ack_active & hs;
    x_cas = x_oe ? ack_level : 3'd0;
    if (x_mst) x_vec = vec_phase & ~hs;
    else       x_vec = vec_phase & (cas_in == my_id);
    x_bus  = x_vec | rd_status;
    x_poe  = (bufcfg >= 2'b10);
    x_pout = x_poe & x_bus;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1/R2 is_master", is_master, x_mst);
    chk("R1/R2 spen_oe",  spen_oe, x_poe);
    chk("R3/R5 cas_oe",   cas_oe, x_oe);
    chk("R3/R4 cas_out",  cas_out, x_cas);
    chk("R6/R7 vec_en",   vec_en, x_vec);
    chk("R8 bus_drive",   bus_drive, x_bus);
    chk("R9 spen_out",    spen_out, x_pout);
  endtask

  // apply inputs at negedge, check at the following negedge
  task automatic step();
    predict();
    @(negedge clk);
    check_all();
  endtask

  task automatic setin(input logic [1:0] c, input logic p, input logic [7:0] m,
                       input logic [2:0] id, input logic a, input logic [2:0] l,
                       input logic v, input logic r, input logic [2:0] ci);
    bufcfg = c; spen_in = p; slave_map = m; my_id = id; ack_active = a;
    ack_level = l; vec_phase = v; rd_status = r; cas_in = ci;
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5eed_c0de);
    // R10: outputs zero under reset even with busy inputs
    setin(2'b11, 1'b1, 8'hFF, 3'd2, 1'b1, 3'd4, 1'b1, 1'b1, 3'd2);
    repeat (3) @(negedge clk);
    chk("R10 cas_oe", cas_oe, 0);
    chk("R10 vec_en", vec_en, 0);
    chk("R10 bus_drive", bus_drive, 0);
    chk("R10 spen_oe", spen_oe, 0);
    chk("R10 is_master", is_master, 0);
    rst_n = 1'b1;

    // R3: master drives level 5 which has a slave
    setin(2'b00, 1'b1, 8'b0010_0000, 3'd0, 1'b1, 3'd5, 1'b1, 1'b0, 3'd0);
    step();
    chk("R3 directed cas_out=5", cas_out, 5);
    // R6: master, level without slave supplies vector
    setin(2'b00, 1'b1, 8'b0010_0000, 3'd0, 1'b1, 3'd4, 1'b1, 1'b0, 3'd0);
    step();
    chk("R6 directed vec_en", vec_en, 1);
    chk("R4 directed cas_oe", cas_oe, 0);
    // R2: buffered slave ignores pin high
    setin(2'b10, 1'b1, 8'hFF, 3'd3, 1'b1, 3'd3, 1'b1, 1'b0, 3'd3);
    step();
    chk("R2 pin ignored", is_master, 0);
    chk("R7 id match", vec_en, 1);
    chk("R9 enable pin", spen_out, 1);
    // R7: mismatching cascade code
    setin(2'b10, 1'b1, 8'hFF, 3'd3, 1'b1, 3'd3, 1'b1, 1'b0, 3'd6);
    step();
    chk("R7 id mismatch", vec_en, 0);
    // R2: buffered master ignores pin low
    setin(2'b11, 1'b0, 8'h80, 3'd0, 1'b1, 3'd7, 1'b0, 1'b0, 3'd0);
    step();
    chk("R2 buffered master", is_master, 1);
    chk("R3 top level", cas_out, 7);
    // R1/R5: pin slave never drives cascade
    setin(2'b01, 1'b0, 8'hFF, 3'd1, 1'b1, 3'd1, 1'b0, 1'b1, 3'd0);
    step();
    chk("R5 slave quiet", cas_oe, 0);
    chk("R8 status read", bus_drive, 1);
    chk("R9 non-buffered pin", spen_out, 0);

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [2:0] id;
      id = 3'($urandom_range(0, 7));
      setin(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            8'($urandom_range(0, 255)), id, 1'($urandom_range(0, 1)),
            3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 3) == 0),
            ($urandom_range(0, 1) != 0) ? id : 3'($urandom_range(0, 7)));
      step();
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule